// File: doc/BRIEF.md
# Mu-law Sample Compander

This block converts speech samples between a 14-bit signed linear form and an 8-bit logarithmically compressed code with mu = 255. The compressed code uses fine steps near zero and coarse steps at high amplitude. This matches the way speech energy is spread and how the ear perceives it. The result is about the quality of a 14-bit linear code at 8 bits per sample, which is 64 kbit/s at 8000 samples per second.

The block has two independent paths. The encoder path takes a linear sample together with a valid strobe. It adds a bias of 33 to the magnitude and clips the sum at 8191. It then finds the segment from the leading one and takes the four bits below that one as the mantissa. It sends sign, segment and mantissa with every bit inverted. The decoder path undoes this: it inverts the code, rebuilds the magnitude at the centre of its quantisation bin, and applies the sign. Each path registers its output one clock after its strobe and can accept a new sample on every cycle.

Top module: `mulaw_compander`

## Requirements
- R1: While reset is high and on the cycle after it, both valid outputs are low and both data outputs are zero.
- R2: One clock after each encoder strobe, `enc_valid_o` is high and the code appears on `enc_code_o`. Strobes on consecutive cycles give codes on consecutive cycles. Without a strobe, `enc_valid_o` is low one clock later.
- R3: The code is the bitwise inverse of {sign, seg[2:0], mant[3:0]}, with sign = 1 for a negative sample. Here b = min(|x| + 33, 8191), seg = (bit position of the leading one of b) - 5, and mant = the four bits of b just below that leading one.
- R4: A zero sample encodes to 0xFF.
- R5: The sample +8191 encodes to 0x80 and the sample -8192 encodes to 0x00.
- R6: One clock after a decoder strobe, `dec_valid_o` is high and `dec_sample_o` holds ±(((mant·2 + 33) << seg) - 33). The fields come from u = ~code: sign = u[7], seg = u[6:4], mant = u[3:0], and the value is negative when u[7] = 1.
- R7: The code 0x7F (negative sign, zero magnitude) decodes to 0. No code decodes to a value outside ±8031.
- R8: On a cycle with no strobe, the data output of that path keeps its last value, whatever is on its data input.
- R9: The two paths are independent. Both can be strobed in the same cycle and each gives its own correct result.
- R10: Decoding the code of any sample x gives a value within 2^(seg+1) of x, where seg is the segment of the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid_i | input | 1 | Encoder sample strobe |
| enc_sample_i | input | 14 | Linear sample, two's complement |
| enc_valid_o | output | 1 | Encoder result strobe |
| enc_code_o | output | 8 | Compressed code, inverted sign/segment/mantissa |
| dec_valid_i | input | 1 | Decoder code strobe |
| dec_code_i | input | 8 | Compressed code to expand |
| dec_valid_o | output | 1 | Decoder result strobe |
| dec_sample_o | output | 14 | Expanded linear sample, two's complement |

## Verification
The assertions assume that reset is held for at least one clock before any strobe, and that the inputs are stable at the rising edge. The bench makes sure of both by driving every input on the falling edge and raising the first strobe only after reset has been released. No restriction on the data values is assumed: every 14-bit pattern and every 8-bit code is legal. For that reason the bench sweeps the whole signed range, including both extremes and the segment edges, and sends codes that lie at the ends of the code space.

// File: rtl/mulaw_pkg.sv
package mulaw_pkg;
  localparam int DEF_LIN_W  = 14;
  localparam int DEF_SEG_W  = 3;
  localparam int DEF_MANT_W = 4;
  localparam int DEF_BIAS   = 33;

  function automatic int mag_limit(input int lin_w);
    return (1 << (lin_w - 1)) - 1;
  endfunction
endpackage

// File: rtl/mulaw_seg_find.sv
module mulaw_seg_find #(
  parameter int SEG_W = 3,
  localparam int NSEG = 1 << SEG_W
) (
  input  logic [NSEG-1:0]  lead_i,
  output logic [SEG_W-1:0] seg_o
);
  // Priority search: the highest set bit names the segment.
  always_comb begin
    seg_o = '0;
    for (int s = 0; s < NSEG; s++) begin
      if (lead_i[s]) seg_o = SEG_W'(s);
    end
  end
endmodule

// File: rtl/mulaw_encoder.sv
module mulaw_encoder import mulaw_pkg::*; #(
  parameter int LIN_W  = DEF_LIN_W,
  parameter int SEG_W  = DEF_SEG_W,
  parameter int MANT_W = DEF_MANT_W,
  parameter int BIAS   = DEF_BIAS,
  localparam int CODE_W  = 1 + SEG_W + MANT_W,
  localparam int MAG_W   = LIN_W - 1,
  localparam int LEAD0   = MANT_W + 1,
  localparam int MAG_MAX = mag_limit(LIN_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [LIN_W-1:0]  sample_i,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o
);
  logic              neg;
  logic [LIN_W-1:0]  mag;
  logic [LIN_W:0]    biased;
  logic [MAG_W-1:0]  clipped;
  logic [SEG_W-1:0]  seg;
  logic [MANT_W-1:0] mant;
  logic [CODE_W-1:0] code_next;

  always_comb begin
    neg     = sample_i[LIN_W-1];
    mag     = neg ? (~sample_i + 1'b1) : sample_i;
    biased  = {1'b0, mag} + (LIN_W+1)'(BIAS);
    clipped = (biased > (LIN_W+1)'(MAG_MAX)) ? MAG_W'(MAG_MAX) : biased[MAG_W-1:0];
  end

  mulaw_seg_find #(.SEG_W(SEG_W)) u_seg_find (
    .lead_i (clipped[MAG_W-1:LEAD0]),
    .seg_o  (seg)
  );

  always_comb begin
    mant      = MANT_W'((clipped >> seg) >> 1);
    code_next = ~{neg, seg, mant};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      code_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) code_o <= code_next;
    end
  end

  AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);  // R2
  AST_ENC_IDLE: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !valid_o);  // R2
  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(code_o));  // R8
  AST_ENC_ZERO: assert property (@(posedge clk) disable iff (rst)
    (valid_i && sample_i == '0) |=> code_o == '1);  // R4
  AST_ENC_SAT_POS: assert property (@(posedge clk) disable iff (rst)
    (valid_i && sample_i == {1'b0, {(LIN_W-1){1'b1}}}) |=> code_o == {1'b1, {(CODE_W-1){1'b0}}});  // R5
  AST_ENC_SAT_NEG: assert property (@(posedge clk) disable iff (rst)
    (valid_i && sample_i == {1'b1, {(LIN_W-1){1'b0}}}) |=> code_o == '0);  // R5
endmodule

// File: rtl/mulaw_decoder.sv
module mulaw_decoder import mulaw_pkg::*; #(
  parameter int LIN_W  = DEF_LIN_W,
  parameter int SEG_W  = DEF_SEG_W,
  parameter int MANT_W = DEF_MANT_W,
  parameter int BIAS   = DEF_BIAS,
  localparam int CODE_W = 1 + SEG_W + MANT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  output logic [LIN_W-1:0]  sample_o
);
  logic [CODE_W-1:0] u;
  logic [SEG_W-1:0]  seg;
  logic [MANT_W-1:0] mant;
  logic [LIN_W-1:0]  base;
  logic [LIN_W-1:0]  mag;
  logic [LIN_W-1:0]  sample_next;

  always_comb begin
    u           = ~code_i;
    seg         = u[CODE_W-2 -: SEG_W];
    mant        = u[MANT_W-1:0];
    base        = LIN_W'({mant, 1'b0}) + LIN_W'(BIAS);
    mag         = (base << seg) - LIN_W'(BIAS);
    sample_next = u[CODE_W-1] ? (~mag + 1'b1) : mag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) sample_o <= sample_next;
    end
  end

  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);  // R6
  AST_DEC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(sample_o) && !valid_o));  // R8
  AST_DEC_SIGN_POS: assert property (@(posedge clk) disable iff (rst)
    (valid_i && code_i[CODE_W-1]) |=> !sample_o[LIN_W-1]);  // R6
  AST_DEC_SIGN_NEG: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !code_i[CODE_W-1] && code_i[CODE_W-2:0] != '1) |=> sample_o[LIN_W-1]);  // R6
  AST_DEC_NEG_ZERO: assert property (@(posedge clk) disable iff (rst)
    (valid_i && code_i == {1'b0, {(CODE_W-1){1'b1}}}) |=> sample_o == '0);  // R7
endmodule

// File: rtl/mulaw_compander.sv
module mulaw_compander import mulaw_pkg::*; #(
  parameter int LIN_W  = DEF_LIN_W,
  parameter int SEG_W  = DEF_SEG_W,
  parameter int MANT_W = DEF_MANT_W,
  parameter int BIAS   = DEF_BIAS,
  localparam int CODE_W = 1 + SEG_W + MANT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enc_valid_i,
  input  logic [LIN_W-1:0]  enc_sample_i,
  output logic              enc_valid_o,
  output logic [CODE_W-1:0] enc_code_o,
  input  logic              dec_valid_i,
  input  logic [CODE_W-1:0] dec_code_i,
  output logic              dec_valid_o,
  output logic [LIN_W-1:0]  dec_sample_o
);
  mulaw_encoder #(
    .LIN_W(LIN_W), .SEG_W(SEG_W), .MANT_W(MANT_W), .BIAS(BIAS)
  ) u_encoder (
    .clk      (clk),
    .rst      (rst),
    .valid_i  (enc_valid_i),
    .sample_i (enc_sample_i),
    .valid_o  (enc_valid_o),
    .code_o   (enc_code_o)
  );

  mulaw_decoder #(
    .LIN_W(LIN_W), .SEG_W(SEG_W), .MANT_W(MANT_W), .BIAS(BIAS)
  ) u_decoder (
    .clk      (clk),
    .rst      (rst),
    .valid_i  (dec_valid_i),
    .code_i   (dec_code_i),
    .valid_o  (dec_valid_o),
    .sample_o (dec_sample_o)
  );
endmodule

// File: tb/test_mulaw_compander.sv
module test_mulaw_compander;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enc_valid_i = 1'b0;
  logic [13:0] enc_sample_i = '0;
  logic        enc_valid_o;
  logic [7:0]  enc_code_o;
  logic        dec_valid_i = 1'b0;
  logic [7:0]  dec_code_i = '0;
  logic        dec_valid_o;
  logic [13:0] dec_sample_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  mulaw_compander i_mulaw_compander (
    .clk(clk), .rst(rst),
    .enc_valid_i(enc_valid_i), .enc_sample_i(enc_sample_i),
    .enc_valid_o(enc_valid_o), .enc_code_o(enc_code_o),
    .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
    .dec_valid_o(dec_valid_o), .dec_sample_o(dec_sample_o)
  );

  // {sample[13:0], code[7:0]}
  localparam logic [21:0] ENC_VEC [12] = '{
    {14'(0), 8'hFF}, {14'(1), 8'hFE}, {14'(-1), 8'h7E}, {14'(30), 8'hF0},
    {14'(31), 8'hEF}, {14'(100), 8'hDF}, {14'(500), 8'hBF}, {14'(1000), 8'hAF},
    {14'(-1000), 8'h2F}, {14'(5000), 8'h8C}, {14'(7902), 8'h81}, {14'(7903), 8'h80}
  };
  // {code[7:0], sample[13:0]}
  localparam logic [21:0] DEC_VEC [8] = '{
    {8'hFF, 14'(0)}, {8'h7F, 14'(0)}, {8'h80, 14'(8031)}, {8'h00, 14'(-8031)},
    {8'hDF, 14'(99)}, {8'h8C, 14'(4959)}, {8'hF0, 14'(30)}, {8'h2F, 14'(-1023)}
  };

  function automatic logic [7:0] ref_enc(input int x);
    int m, b, s, mt;
    logic sg;
    sg = (x < 0);
    m  = sg ? -x : x;
    b  = m + 33;
    if (b > 8191) b = 8191;
    s = 0;
    for (int k = 1; k < 8; k++) if (b >= (32 << k)) s = k;
    mt = (b >> (s + 1)) - 16;
    return ~{sg, 3'(s), 4'(mt)};
  endfunction

  function automatic int ref_dec(input logic [7:0] c);
    logic [7:0] u;
    int m;
    u = ~c;
    m = (((int'(u[3:0]) * 2) + 33) << u[6:4]) - 33;
    return u[7] ? -m : m;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sdec();
    return int'($signed(dec_sample_o));
  endfunction

  task automatic enc_one(input int x, input string req);
    @(negedge clk);
    enc_sample_i = 14'(x);
    enc_valid_i  = 1'b1;
    @(negedge clk);
    enc_valid_i  = 1'b0;
    check(enc_valid_o, req, enc_valid_o, 1);
    check(enc_code_o == ref_enc(x), req, enc_code_o, ref_enc(x));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!enc_valid_o && !dec_valid_o, "R1 valid", enc_valid_o + dec_valid_o, 0);
    check(enc_code_o == 0 && dec_sample_o == 0, "R1 data", enc_code_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!enc_valid_o && enc_code_o == 0, "R1 after release", enc_code_o, 0);

    // R3 R4 R5: encoder table
    foreach (ENC_VEC[i]) begin
      @(negedge clk);
      enc_sample_i = ENC_VEC[i][21:8];
      enc_valid_i  = 1'b1;
      @(negedge clk);
      enc_valid_i  = 1'b0;
      check(enc_valid_o, "R2 enc valid", enc_valid_o, 1);
      check(enc_code_o == ENC_VEC[i][7:0], "R3 enc table", enc_code_o, ENC_VEC[i][7:0]);
    end
    enc_one(8191, "R5 positive full scale");
    check(enc_code_o == 8'h80, "R5 +8191", enc_code_o, 8'h80);
    enc_one(-8192, "R5 negative full scale");
    check(enc_code_o == 8'h00, "R5 -8192", enc_code_o, 8'h00);
    enc_one(0, "R4 zero");
    check(enc_code_o == 8'hFF, "R4 zero code", enc_code_o, 8'hFF);

    // R6 R7: decoder table
    foreach (DEC_VEC[i]) begin
      @(negedge clk);
      dec_code_i  = DEC_VEC[i][21:14];
      dec_valid_i = 1'b1;
      @(negedge clk);
      dec_valid_i = 1'b0;
      check(dec_valid_o, "R6 dec valid", dec_valid_o, 1);
      check(sdec() == int'($signed(DEC_VEC[i][13:0])), "R6 R7 dec table",
            sdec(), int'($signed(DEC_VEC[i][13:0])));
    end

    // R2: back-to-back strobes
    @(negedge clk);
    enc_sample_i = 14'(100); enc_valid_i = 1'b1;
    @(negedge clk);
    check(enc_code_o == 8'hDF && enc_valid_o, "R2 burst 0", enc_code_o, 8'hDF);
    enc_sample_i = 14'(-1);
    @(negedge clk);
    check(enc_code_o == 8'h7E && enc_valid_o, "R2 burst 1", enc_code_o, 8'h7E);
    enc_sample_i = 14'(5000);
    @(negedge clk);
    check(enc_code_o == 8'h8C && enc_valid_o, "R2 burst 2", enc_code_o, 8'h8C);
    enc_valid_i = 1'b0;
    @(negedge clk);
    check(!enc_valid_o, "R2 idle after burst", enc_valid_o, 0);

    // R8: inputs change without a strobe
    enc_sample_i = 14'(1000);
    dec_code_i   = 8'h00;
    repeat (3) @(negedge clk);
    check(enc_code_o == 8'h8C, "R8 enc hold", enc_code_o, 8'h8C);
    check(!enc_valid_o && !dec_valid_o, "R8 no valid", enc_valid_o, 0);
    check(sdec() == -1023, "R8 dec hold", sdec(), -1023);

    // R9: both paths in the same cycle
    @(negedge clk);
    enc_sample_i = 14'(-1000); enc_valid_i = 1'b1;
    dec_code_i   = 8'h80;      dec_valid_i = 1'b1;
    @(negedge clk);
    enc_valid_i = 1'b0; dec_valid_i = 1'b0;
    check(enc_code_o == 8'h2F, "R9 enc side", enc_code_o, 8'h2F);
    check(sdec() == 8031, "R9 dec side", sdec(), 8031);

    // R3 R6 R10: sweep through the range and round trip
    for (int x = -8192; x <= 8191; x += 37) begin
      enc_one(x, "R3 sweep");
      dec_code_i  = enc_code_o;
      dec_valid_i = 1'b1;
      @(negedge clk);
      dec_valid_i = 1'b0;
      begin
        int y, err, seg;
        y   = sdec();
        seg = int'((~dec_code_i) >> 4) & 7;
        err = (x > y) ? x - y : y - x;
        check(y == ref_dec(dec_code_i), "R6 sweep", y, ref_dec(dec_code_i));
        check(err <= (2 << seg), "R10 round trip", err, 2 << seg);
      end
    end

    // R1: reset in the middle of operation
    enc_one(5000, "R1 pre-reset");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(enc_code_o == 0 && dec_sample_o == 0, "R1 mid reset", enc_code_o, 0);
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule